// File: doc/BRIEF.md
# Address Bit 20 Mask Unit

This block sits in the physical address path between the processor core and its cache lookup and external memory cycles. It can clear bit 20 of each outgoing physical address, so that addresses just above the 1-Mbyte boundary wrap to the bottom of memory. This is how real-mode programs that rely on that wraparound expect memory to behave. The request to wrap comes from an active-low pin that system logic may drive with no relation to the clock. The block passes that pin through a two-flop synchronizer.

The synchronized request is qualified before it touches an address. It is checked against the operating mode, which is real, protected or system management. It is also checked against the kind of cycle carrying the address, which is a normal access, a snoop inquire or a writeback. A short capture window right after reset decides whether the first address strobe is wrapped. Each address is latched on its valid strobe and leaves one clock later, together with a flag that shows whether bit 20 was cleared. A sticky status bit records any use of the pin in protected mode, where wrapping has no defined meaning.

Top module: `addr_wrap_mask`

## Requirements
- R1: When wrapping applies to a strobe, output address bit 20 is 0 and `masked_o` is 1. Every other address bit always equals the latched input address.
- R2: `addr_vld_o` is 1 exactly one clock after each edge that samples `addr_vld_i` high. `addr_o` and `masked_o` are registered. `masked_o` is 0 in any cycle where `addr_vld_o` is 0.
- R3: The pin is synchronized through two flops. A low level sampled at edge k affects strobes sampled at edge k+2 and later. A low pulse that no rising edge samples has no effect. A low pulse that lasts two clocks or more is always seen.
- R4: Strobes with cycle kind 2'b01 (inquire) or 2'b10 (writeback) are never wrapped. Kinds 2'b00 and 2'b11 are normal accesses.
- R5: In system management mode (mode code 2'b10), an asserted pin is ignored and addresses pass unchanged.
- R6: Wrapping happens only in real mode (mode code 2'b00). In protected mode (codes 2'b01 and 2'b11) nothing is wrapped. `undef_use_o` becomes 1 one edge after the synchronized request is seen high in protected mode, and it stays 1 until reset.
- R7: Edge 0 is the first rising edge that samples reset low. The first strobe after reset is wrapped if the pin was sampled low on edge 0, 1 or 2, provided that strobe comes on edge 4 or later. A low sample only on edge 3 does not wrap that first strobe.
- R8: After the first strobe following reset, each strobe uses the current synchronized request level.
- R9: While reset is sampled high, `addr_vld_o`, `masked_o`, `undef_use_o` and `addr_o` clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrap_req_n | input | 1 | Active-low wrap request, may be asynchronous |
| mode_i | input | 2 | Operating mode: 00 real, 01/11 protected, 10 system management |
| cyc_kind_i | input | 2 | Cycle kind: 00/11 normal, 01 inquire, 10 writeback |
| addr_i | input | 32 | Physical address from the core |
| addr_vld_i | input | 1 | Address valid strobe |
| addr_o | output | 32 | Registered address, bit 20 possibly cleared |
| addr_vld_o | output | 1 | Output address valid |
| masked_o | output | 1 | Bit 20 was cleared for this output |
| undef_use_o | output | 1 | Sticky: request seen in protected mode |

## Verification
The hardest situation to reach is the post-reset window, where the pin must be low on exactly one chosen edge. The bench releases reset on a known falling edge and then moves the pin on the falling edges that follow. This places a single low sample on edge 0, 1, 2 or 3. The first strobe is held back until edge 6, so only the window capture decides its result. Asynchronous pulses are started a few time units after a rising edge. A pulse of half a clock then falls between two edges, while a pulse of two clocks spans two of them.

// File: rtl/awm_pkg.sv
package awm_pkg;

    typedef enum logic [1:0] {
        MODE_REAL     = 2'b00,
        MODE_PROT     = 2'b01,
        MODE_SMM      = 2'b10,
        MODE_PROT_ALT = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        CYC_NORMAL     = 2'b00,
        CYC_INQUIRE    = 2'b01,
        CYC_WRBACK     = 2'b10,
        CYC_NORMAL_ALT = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        logic apply;
        logic undef_hit;
    } qual_s;

    function automatic logic mode_is_real(op_mode_e m);
        return m == MODE_REAL;
    endfunction

    function automatic logic mode_is_prot(op_mode_e m);
        return (m == MODE_PROT) || (m == MODE_PROT_ALT);
    endfunction

    function automatic logic kind_is_maskable(cyc_kind_e k);
        return (k == CYC_NORMAL) || (k == CYC_NORMAL_ALT);
    endfunction

endpackage

// File: rtl/awm_sync.sv
module awm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic first_o,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ~async_n;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign first_o = chain[0];
    assign sync_o  = chain[STAGES-1];
endmodule

// File: rtl/awm_window.sv
module awm_window #(
    parameter int WIN_EDGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic early_i,
    input  logic strobe_i,
    output logic pend_o,
    output logic cap_o
);
    localparam int CNT_W = $clog2(WIN_EDGES + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_EDGES);

    logic [CNT_W-1:0] edge_cnt;
    logic             in_window;

    assign in_window = (edge_cnt != '0) && (edge_cnt <= LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt <= '0;
            cap_o    <= 1'b0;
            pend_o   <= 1'b1;
        end else begin
            if (edge_cnt <= LAST) edge_cnt <= edge_cnt + 1'b1;
            if (in_window && early_i) cap_o <= 1'b1;
            if (strobe_i) pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/awm_qual.sv
module awm_qual
    import awm_pkg::*;
(
    input  op_mode_e  mode_i,
    input  cyc_kind_e kind_i,
    input  logic      req_i,
    input  logic      sync_i,
    output qual_s     q_o
);
    always_comb begin
        q_o           = '0;
        q_o.apply     = req_i && mode_is_real(mode_i) && kind_is_maskable(kind_i);
        q_o.undef_hit = sync_i && mode_is_prot(mode_i);
    end
endmodule

// File: rtl/addr_wrap_mask.sv
module addr_wrap_mask
    import awm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WRAP_BIT    = 20,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_EDGES   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_req_n,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        cyc_kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              masked_o,
    output logic              undef_use_o
);
    localparam logic [ADDR_W-1:0] WRAP_MASK = ADDR_W'(1) << WRAP_BIT;

    logic  early_req;
    logic  sync_req;
    logic  first_pend;
    logic  win_cap;
    logic  eff_req;
    qual_s qual;

    awm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (wrap_req_n),
        .first_o (early_req),
        .sync_o  (sync_req)
    );

    awm_window #(.WIN_EDGES(WIN_EDGES)) u_window (
        .clk      (clk),
        .rst      (rst),
        .early_i  (early_req),
        .strobe_i (addr_vld_i),
        .pend_o   (first_pend),
        .cap_o    (win_cap)
    );

    assign eff_req = first_pend ? win_cap : sync_req;

    awm_qual u_qual (
        .mode_i (op_mode_e'(mode_i)),
        .kind_i (cyc_kind_e'(cyc_kind_i)),
        .req_i  (eff_req),
        .sync_i (sync_req),
        .q_o    (qual)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o      <= '0;
            addr_vld_o  <= 1'b0;
            masked_o    <= 1'b0;
            undef_use_o <= 1'b0;
        end else begin
            addr_vld_o <= addr_vld_i;
            masked_o   <= addr_vld_i && qual.apply;
            if (addr_vld_i)
                addr_o <= qual.apply ? (addr_i & ~WRAP_MASK) : addr_i;
            if (qual.undef_hit) undef_use_o <= 1'b1;
        end
    end
endmodule

// File: rtl/awm_checker.sv
module awm_checker #(
    parameter int ADDR_W   = 32,
    parameter int WRAP_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_i,
    input logic [1:0]        cyc_kind_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              addr_vld_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_vld_o,
    input logic              masked_o,
    input logic              undef_use_o
);
    localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << WRAP_BIT);

    assert_masked_clears_R1: assert property (@(posedge clk) disable iff (rst)
        masked_o |-> (addr_o[WRAP_BIT] == 1'b0));

    assert_other_bits_R1: assert property (@(posedge clk) disable iff (rst)
        addr_vld_o |-> ((addr_o & KEEP) == ($past(addr_i) & KEEP)));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        addr_vld_i |=> addr_vld_o);

    assert_flag_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        masked_o |-> addr_vld_o);

    assert_bypass_kinds_R4: assert property (@(posedge clk) disable iff (rst)
        (addr_vld_o && ($past(cyc_kind_i) == 2'b01 || $past(cyc_kind_i) == 2'b10))
        |-> (!masked_o && addr_o[WRAP_BIT] == $past(addr_i[WRAP_BIT])));

    assert_smm_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_vld_o && $past(mode_i) == 2'b10) |-> !masked_o);

    assert_real_only_R6: assert property (@(posedge clk) disable iff (rst)
        masked_o |-> ($past(mode_i) == 2'b00));

    assert_undef_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        undef_use_o |=> undef_use_o);
endmodule

bind addr_wrap_mask awm_checker #(.ADDR_W(ADDR_W), .WRAP_BIT(WRAP_BIT)) u_awm_checker (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .cyc_kind_i  (cyc_kind_i),
    .addr_i      (addr_i),
    .addr_vld_i  (addr_vld_i),
    .addr_o      (addr_o),
    .addr_vld_o  (addr_vld_o),
    .masked_o    (masked_o),
    .undef_use_o (undef_use_o)
);

// File: tb/test_addr_wrap_mask.sv
module test_addr_wrap_mask;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wrap_req_n = 1'b1;
    logic [1:0]  mode_i = 2'b00;
    logic [1:0]  cyc_kind_i = 2'b00;
    logic [31:0] addr_i = '0;
    logic        addr_vld_i = 1'b0;
    logic [31:0] addr_o;
    logic        addr_vld_o, masked_o, undef_use_o;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 0;

    addr_wrap_mask i_addr_wrap_mask (
        .clk(clk), .rst(rst), .wrap_req_n(wrap_req_n), .mode_i(mode_i),
        .cyc_kind_i(cyc_kind_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o), .masked_o(masked_o),
        .undef_use_o(undef_use_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit          hist[$];
    int          edges_since;
    bit          cap, first, undef_m;
    bit          e_vld, e_masked;
    logic [31:0] e_addr;
    string       e_tag;

    always @(posedge clk) begin
        bit s2, eff, req, normal;
        if (rst) begin
            hist = '{0, 0};
            edges_since = 0; cap = 0; first = 1; undef_m = 0;
            e_vld = 0; e_masked = 0; e_addr = '0; e_tag = "R9";
            started = 1;
        end else begin
            s2  = hist[1];
            req = first ? cap : s2;
            normal = (cyc_kind_i == 2'b00) || (cyc_kind_i == 2'b11);
            eff = req && (mode_i == 2'b00) && normal;
            if (addr_vld_i) begin
                e_tag = first ? "R7" : (!normal ? "R4" : (mode_i == 2'b10 ? "R5" :
                        (mode_i != 2'b00 ? "R6" : (eff ? "R1" : "R3"))));
                e_addr = eff ? (addr_i & ~(32'h1 << 20)) : addr_i;
                first = 0;
            end else e_tag = "R2";
            e_vld = addr_vld_i;
            e_masked = addr_vld_i && eff;
            if ((mode_i == 2'b01 || mode_i == 2'b11) && s2) undef_m = 1;
            if (edges_since < 3 && !wrap_req_n) cap = 1;
            if (edges_since < 10) edges_since++;
            hist.push_front(!wrap_req_n);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk({e_tag, " R2 valid"}, 32'(addr_vld_o), 32'(e_vld));
            chk({e_tag, " masked"}, 32'(masked_o), 32'(e_masked));
            chk("R6 undef", 32'(undef_use_o), 32'(undef_m));
            if (e_vld || rst) chk({e_tag, " addr"}, addr_o, e_addr);
        end
    end

    task automatic strobe(logic [1:0] m, logic [1:0] k, logic [31:0] a);
        mode_i = m; cyc_kind_i = k; addr_i = a; addr_vld_i = 1'b1;
        @(negedge clk);
        addr_vld_i = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R7: pin sampled low only on edge k (and later if hold)
    task automatic win_reset(int k, bit hold);
        @(negedge clk);
        rst = 1'b1; wrap_req_n = 1'b1; mode_i = 2'b00;
        idle(3);
        rst = 1'b0;
        for (int j = 0; j < 6; j++) begin
            wrap_req_n = (j == k || (hold && j > k)) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
        strobe(2'b00, 2'b00, 32'h0012_3456);   // first strobe, R7
        idle(1);
        strobe(2'b00, 2'b00, 32'h0013_0000);   // R8 follows level
        idle(1);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(4);                                  // R9 reset state checked
        win_reset(0, 0);
        win_reset(1, 0);
        win_reset(2, 0);
        win_reset(3, 0);                          // fourth edge: not wrapped
        win_reset(3, 1);                          // R8: second strobe wrapped
        win_reset(-1, 0);
        // sustained request, all kinds and modes (R1 R4 R5 R6)
        wrap_req_n = 1'b0; idle(3);
        for (int k = 0; k < 4; k++)
            for (int m = 0; m < 4; m++)
                strobe(2'(m), 2'(k), 32'hFFFF_FFFF ^ (32'(k) << 4));
        wrap_req_n = 1'b1; idle(3);
        strobe(2'b00, 2'b00, 32'h0010_0000);
        // R3: short async pulse between edges is never sampled
        @(posedge clk); #2 wrap_req_n = 1'b0; #(PERIOD/2) wrap_req_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) strobe(2'b00, 2'b00, 32'h0011_0000 + 32'(i));
        // R3: two-clock async pulse is seen
        @(posedge clk); #3 wrap_req_n = 1'b0; #(2*PERIOD) wrap_req_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) strobe(2'b00, 2'b00, 32'h0031_0000 + 32'(i));
        // random traffic
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 5) == 0) wrap_req_n = ~wrap_req_n;
            mode_i = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
            cyc_kind_i = 2'($urandom);
            addr_i = $urandom;
            addr_vld_i = $urandom_range(0, 1) == 1;
            @(negedge clk);
        end
        addr_vld_i = 1'b0;
        idle(3);
        rst = 1'b1; idle(2);                      // R9 again: undef clears
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule